// File: doc/BRIEF.md
# Message Mailbox Slot

The block is one slot of a mailbox that moves whole messages of 32-bit words from a producer to a consumer. Storage is a ring of entries. The number of entries is a power of two, and each entry holds a power-of-two number of words. Both sides use the same small register window. Each register sits at word index `regAddr`, which is the byte offset divided by four. Index 0 is a write-only command register, index 1 is the status register, and index 2 onward is the data area of one entry.

To send, the producer first checks that the slot is not full and claims an entry. It writes the message words into the data area, then commits the message together with its length. To receive, the consumer reads the length of the head message from status, reads that many words, then discards the message. A purge command empties the slot at once. Writes take effect at the clock edge on which `wrEn` is sampled. A read launched with `rdEn` returns its value on `rdData` after the next clock edge.

Top module: `mbox_slot`

## Requirements
- R1: After reset the status word reads as follows. Bit 0 (full) is 0 and bit 1 (empty) is 1. Bits [15:8] (occupied count) and [23:16] (head length) are 0. Bits [7:2] hold log2 of the entry count, bits [31:28] hold log2 of the words per entry, and bits [27:24] are 0.
- R2: The register map is: index 0 is the command register, index 1 is status, and index 2+i is data word i. Reading the command register returns zero. Read data appears on `rdData` one clock after the read strobe.
- R3: Command bit 24 claims an entry while the slot is not full. Data writes after a claim land in the write-pointer entry. Command bit 26 commits the claimed entry with the length taken from bits [7:0] of the same write. A commit raises the occupied count by one and releases the claim.
- R4: A commit issued without an active claim has no effect. A data write issued without an active claim has no effect.
- R5: Data reads return words of the read-pointer (head) entry. Command bit 27 discards the head message, advances to the next one, and lowers the occupied count by one.
- R6: The full flag is set when the occupied count equals the entry count. While full, a claim, a commit and a data write change neither the pointers, the count nor the stored words.
- R7: A discard while the slot is empty changes neither the read pointer nor the count.
- R8: Command bit 25 (purge) clears both pointers, the count and the claim in one clock. It overrides every other command bit set in the same write.
- R9: A data write to a word index at or beyond the entry width is ignored. A read of such an index returns zero.
- R10: Writes to the status register are ignored.
- R11: Messages leave in commit order, including when the pointers wrap around the ring.
- R12: A single write that carries both commit (with an active claim) and discard on a non-empty slot performs both. The count is left unchanged and the head moves to the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | LOG2_WORDS+1 | Word index into the slot window |
| wrData | input | 32 | Write data or command word |
| rdData | output | 32 | Read data, valid the clock after `rdEn` |

## Verification
A command or data write is applied on the rising edge that samples `wrEn`. Its effect on the pointers, the count and the stored words can therefore be seen by any read launched after that edge. A read registers its result on the edge that samples `rdEn`, so `rdData` carries the value one cycle later. The bench drives each strobe for exactly one cycle from a falling edge and deasserts it at the next falling edge. It samples `rdData` at that same falling edge, half a period after the register loaded. Every "no effect" case is judged by reading status or data words back through the window after the stimulus.

// File: rtl/mbox_slot_pkg.sv
package mbox_slot_pkg;

  // command word bit positions (the software side depends on these)
  localparam int CMD_CLAIM   = 24;
  localparam int CMD_PURGE   = 25;
  localparam int CMD_COMMIT  = 26;
  localparam int CMD_DISCARD = 27;

  // strobes from control to datapath
  typedef struct packed {
    logic memWr;   // store wrData into the claimed entry
    logic lenWr;   // record committed length
    logic rdStat;  // read returns status word
    logic rdWord;  // read returns a head-entry word
    logic rdAny;   // any read this cycle
  } slotStrbT;

endpackage

// File: rtl/mbox_slot_ctrl.sv
module mbox_slot_ctrl
  import mbox_slot_pkg::*;
#(
  parameter int LOG2_ENTRIES = 2,
  parameter int LOG2_WORDS   = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [LOG2_WORDS:0]     regAddr,
  input  logic [3:0]              cmdBits,
  output slotStrbT                strb,
  output logic [LOG2_WORDS-1:0]   wordIdx,
  output logic [LOG2_ENTRIES-1:0] wrPtr,
  output logic [LOG2_ENTRIES-1:0] rdPtr,
  output logic [LOG2_ENTRIES:0]   cnt,
  output logic                    full,
  output logic                    empty
);

  localparam int ENTRIES = 1 << LOG2_ENTRIES;
  localparam int WORDS   = 1 << LOG2_WORDS;
  localparam int AW      = LOG2_WORDS + 1;

  logic          claimed;
  logic          isCmd, isStat, isData;
  logic [AW-1:0] dataOff;
  logic          cmdWr, doPurge, doClaim, doCommit, doDiscard;

  // address decode
  always_comb begin
    isCmd   = (regAddr == AW'(0));
    isStat  = (regAddr == AW'(1));
    dataOff = regAddr - AW'(2);
    isData  = (regAddr >= AW'(2)) && (dataOff < AW'(WORDS));
    wordIdx = dataOff[LOG2_WORDS-1:0];
  end

  assign full  = (cnt == (LOG2_ENTRIES+1)'(ENTRIES));
  assign empty = (cnt == '0);

  // command decode; purge dominates
  always_comb begin
    cmdWr     = wrEn && isCmd;
    doPurge   = cmdWr && cmdBits[CMD_PURGE-CMD_CLAIM];
    doClaim   = cmdWr && cmdBits[0] && !doPurge && !full;
    doCommit  = cmdWr && cmdBits[CMD_COMMIT-CMD_CLAIM] && !doPurge && claimed && !full;
    doDiscard = cmdWr && cmdBits[CMD_DISCARD-CMD_CLAIM] && !doPurge && !empty;
  end

  always_comb begin
    strb.memWr  = wrEn && isData && claimed && !full;
    strb.lenWr  = doCommit;
    strb.rdStat = rdEn && isStat;
    strb.rdWord = rdEn && isData;
    strb.rdAny  = rdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      cnt     <= '0;
      claimed <= 1'b0;
    end else if (doPurge) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      cnt     <= '0;
      claimed <= 1'b0;
    end else begin
      if (doCommit)       claimed <= 1'b0;
      else if (doClaim)   claimed <= 1'b1;
      if (doCommit)  wrPtr <= wrPtr + 1'b1;
      if (doDiscard) rdPtr <= rdPtr + 1'b1;
      if (doCommit && !doDiscard)      cnt <= cnt + 1'b1;
      else if (doDiscard && !doCommit) cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/mbox_slot_dp.sv
module mbox_slot_dp
  import mbox_slot_pkg::*;
#(
  parameter int LOG2_ENTRIES = 2,
  parameter int LOG2_WORDS   = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  slotStrbT                strb,
  input  logic [LOG2_ENTRIES-1:0] wrPtr,
  input  logic [LOG2_ENTRIES-1:0] rdPtr,
  input  logic [LOG2_WORDS-1:0]   wordIdx,
  input  logic [LOG2_ENTRIES:0]   cnt,
  input  logic                    full,
  input  logic                    empty,
  input  logic [31:0]             wrData,
  output logic [31:0]             rdData
);

  localparam int ENTRIES = 1 << LOG2_ENTRIES;
  localparam int WORDS   = 1 << LOG2_WORDS;
  localparam int DEPTH   = ENTRIES * WORDS;

  logic [31:0] mem [DEPTH];
  logic [7:0]  lenMem [ENTRIES];
  logic [7:0]  headLen;
  logic [31:0] statusWord;

  always_ff @(posedge clk) begin
    if (strb.memWr) mem[{wrPtr, wordIdx}] <= wrData;
  end

  // per-entry length registers
  for (genvar e = 0; e < ENTRIES; e++) begin : g_len
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lenMem[e] <= '0;
      else if (strb.lenWr && (wrPtr == LOG2_ENTRIES'(e)))
        lenMem[e] <= wrData[7:0];
    end
  end

  always_comb begin
    headLen    = empty ? 8'd0 : lenMem[rdPtr];
    statusWord = {4'(LOG2_WORDS), 4'b0000, headLen, 8'(cnt),
                  6'(LOG2_ENTRIES), empty, full};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (strb.rdAny) begin
      if (strb.rdStat)      rdData <= statusWord;
      else if (strb.rdWord) rdData <= mem[{rdPtr, wordIdx}];
      else                  rdData <= '0;
    end
  end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
  import mbox_slot_pkg::*;
#(
  parameter int LOG2_ENTRIES = 2,
  parameter int LOG2_WORDS   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [LOG2_WORDS:0]   regAddr,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData
);

  slotStrbT                strb;
  logic [LOG2_WORDS-1:0]   wordIdx;
  logic [LOG2_ENTRIES-1:0] wrPtr, rdPtr;
  logic [LOG2_ENTRIES:0]   cnt;
  logic                    full, empty;

  mbox_slot_ctrl #(.LOG2_ENTRIES(LOG2_ENTRIES), .LOG2_WORDS(LOG2_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .cmdBits(wrData[CMD_DISCARD:CMD_CLAIM]), .strb(strb), .wordIdx(wordIdx),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .cnt(cnt), .full(full), .empty(empty)
  );

  mbox_slot_dp #(.LOG2_ENTRIES(LOG2_ENTRIES), .LOG2_WORDS(LOG2_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wordIdx(wordIdx), .cnt(cnt), .full(full), .empty(empty),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/mbox_slot_chk.sv
module mbox_slot_chk #(
  parameter int LOG2_ENTRIES = 2,
  parameter int LOG2_WORDS   = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [LOG2_WORDS:0]     regAddr,
  input logic [3:0]              cmdBits,
  input logic [31:0]             rdData,
  input logic [LOG2_ENTRIES-1:0] wrPtr,
  input logic [LOG2_ENTRIES-1:0] rdPtr,
  input logic [LOG2_ENTRIES:0]   cnt
);

  localparam int ENTRIES = 1 << LOG2_ENTRIES;
  localparam int AW      = LOG2_WORDS + 1;

  logic cmdWr;
  assign cmdWr = wrEn && (regAddr == AW'(0));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= (LOG2_ENTRIES+1)'(ENTRIES));

  p_ptr_gap_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr - rdPtr) == cnt[LOG2_ENTRIES-1:0]);

  p_purge_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && cmdBits[1] |=> (cnt == '0) && (wrPtr == '0) && (rdPtr == '0));

  p_discard_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && cmdBits[3] && !cmdBits[1] && !cmdBits[2] && (cnt == '0)
    |=> (cnt == '0) && $stable(rdPtr));

  p_commit_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && cmdBits[2] && !cmdBits[1] && !cmdBits[3]
    && (cnt == (LOG2_ENTRIES+1)'(ENTRIES))
    |=> $stable(wrPtr) && $stable(cnt));

  p_claim_keeps_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && (cmdBits == 4'b0001) |=> $stable(cnt) && $stable(wrPtr));

  p_cmd_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (regAddr == AW'(0)) |=> rdData == 32'd0);

  p_status_write_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (regAddr == AW'(1)) |=> $stable(cnt) && $stable(wrPtr) && $stable(rdPtr));

endmodule

bind mbox_slot mbox_slot_chk #(.LOG2_ENTRIES(LOG2_ENTRIES), .LOG2_WORDS(LOG2_WORDS)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
  .cmdBits(wrData[27:24]), .rdData(rdData), .wrPtr(wrPtr), .rdPtr(rdPtr), .cnt(cnt)
);

// File: tb/tb_mbox_slot.sv
`timescale 1ns/1ps
module tb_mbox_slot;

  localparam int LE = 2;
  localparam int LW = 3;
  localparam int NENT = 1 << LE;
  localparam int NWORD = 1 << LW;
  localparam logic [31:0] C_CLAIM   = 32'h0100_0000;
  localparam logic [31:0] C_PURGE   = 32'h0200_0000;
  localparam logic [31:0] C_COMMIT  = 32'h0400_0000;
  localparam logic [31:0] C_DISCARD = 32'h0800_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [LW:0] regAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mbox_slot #(.LOG2_ENTRIES(LE), .LOG2_WORDS(LW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [31:0] stat(input bit f, input bit e, input int c, input int l);
    return {4'(LW), 4'h0, 8'(l), 8'(c), 6'(LE), e, f};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = (LW+1)'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    rdEn = 1'b1; regAddr = (LW+1)'(a);
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1, v); chk("R1 status after reset", v, stat(0, 1, 0, 0));
    rd(0, v); chk("R2 command reads zero", v, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    wr(0, C_CLAIM);
    for (int i = 0; i < 3; i++) wr(2 + i, 32'hA000_0000 + i);
    rd(1, v); chk("R3 claim alone keeps slot empty", v, stat(0, 1, 0, 0));
    wr(0, C_COMMIT | 32'd3);
    rd(1, v); chk("R3 status after commit", v, stat(0, 0, 1, 3));
    for (int i = 0; i < 3; i++) begin
      rd(2 + i, v); chk("R5 head word read", v, 32'hA000_0000 + i);
    end
    wr(0, C_DISCARD);
    rd(1, v); chk("R5 status after discard", v, stat(0, 1, 0, 0));
  endtask

  task automatic t_noclaim;
    logic [31:0] v;
    wr(0, C_COMMIT | 32'd5);
    rd(1, v); chk("R4 commit without claim ignored", v, stat(0, 1, 0, 0));
  endtask

  task automatic t_beyond;
    logic [31:0] v;
    wr(0, C_CLAIM);
    for (int i = 0; i < NWORD; i++) wr(2 + i, 32'h100 + i);
    wr(2 + NWORD, 32'h0BAD);
    wr(0, C_COMMIT | NWORD);
    rd(1, v); chk("R9 full-width message length", v, stat(0, 0, 1, NWORD));
    rd(2, v); chk("R9 word 0 untouched by out-of-range write", v, 32'h100);
    rd(1 + NWORD, v); chk("R9 last word", v, 32'h100 + NWORD - 1);
    rd(2 + NWORD, v); chk("R9 out-of-range read is zero", v, 32'd0);
    wr(0, C_DISCARD);
  endtask

  task automatic t_status_write;
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R10 status write ignored", v, stat(0, 1, 0, 0));
  endtask

  task automatic t_fill_wrap;
    logic [31:0] v;
    for (int k = 0; k < NENT; k++) begin
      wr(0, C_CLAIM);
      wr(2, 32'h200 + k);
      wr(0, C_COMMIT | (k + 1));
    end
    rd(1, v); chk("R6 full flag set", v, stat(1, 0, NENT, 1));
    wr(0, C_CLAIM);
    wr(2, 32'h0EEE);
    wr(0, C_COMMIT | 32'd7);
    rd(1, v); chk("R6 claim and commit while full ignored", v, stat(1, 0, NENT, 1));
    rd(2, v); chk("R4 R6 data write while full ignored", v, 32'h200);
    for (int k = 0; k < NENT; k++) begin
      rd(1, v); chk("R11 head length in order", v, stat(k == 0, 0, NENT - k, k + 1));
      rd(2, v); chk("R11 head word in order across wrap", v, 32'h200 + k);
      wr(0, C_DISCARD);
    end
    rd(1, v); chk("R11 empty after draining", v, stat(0, 1, 0, 0));
  endtask

  task automatic t_discard_empty;
    logic [31:0] v;
    wr(0, C_DISCARD);
    rd(1, v); chk("R7 discard on empty ignored", v, stat(0, 1, 0, 0));
    wr(0, C_CLAIM);
    wr(2, 32'h0777);
    wr(0, C_COMMIT | 32'd2);
    rd(1, v); chk("R7 count after later commit", v, stat(0, 0, 1, 2));
    rd(2, v); chk("R7 read pointer not moved", v, 32'h0777);
  endtask

  task automatic t_commit_discard;
    logic [31:0] v;
    wr(0, C_CLAIM);
    wr(2, 32'h0300);
    wr(0, C_COMMIT | C_DISCARD | 32'd4);
    rd(1, v); chk("R12 count kept, new head length", v, stat(0, 0, 1, 4));
    rd(2, v); chk("R12 new head word", v, 32'h0300);
  endtask

  task automatic t_purge;
    logic [31:0] v;
    wr(0, C_CLAIM);
    wr(0, C_PURGE | C_COMMIT | 32'd5);
    rd(1, v); chk("R8 purge wins over commit", v, stat(0, 1, 0, 0));
    wr(0, C_COMMIT | 32'd3);
    rd(1, v); chk("R8 purge released the claim", v, stat(0, 1, 0, 0));
    wr(0, C_CLAIM);
    wr(2, 32'h0400);
    wr(0, C_COMMIT | 32'd1);
    rd(1, v); chk("R8 slot usable after purge", v, stat(0, 0, 1, 1));
    rd(2, v); chk("R8 word after purge", v, 32'h0400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_noclaim();
    t_beyond();
    t_status_write();
    t_fill_wrap();
    t_discard_empty();
    t_commit_discard();
    t_purge();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule